// File: doc/BRIEF.md
# Quantized INT8 Softmax Datapath

This block turns a vector of K signed 8-bit attention scores into K signed 8-bit softmax weights. It uses only integer arithmetic and two programmable 256-entry byte tables. Each score is a fixed-point byte with six fractional bits, so the real value is the raw byte divided by 64.

The block takes one vector at a time through a valid/ready handshake and works through a short fixed sequence of steps. First it finds the signed lane maximum and subtracts it from every lane, saturating the difference. It looks up an exponential for each lane and sums the looked-up bytes as signed values. It clamps that sum and looks up a single reciprocal. Each lane then multiplies its exponential by the reciprocal, floor-shifts the product right by seven, and saturates the result to a byte. The result appears for exactly one cycle on a valid-only output.

A separate write port loads both tables. Software fills them before the first vector is sent. Floating-point dequantization is done upstream, so the scores arrive already quantized.

Top module: `sq8_softmax`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: A vector is accepted on a rising edge where in_valid and in_ready are both 1. in_ready then stays 0 until the result has been delivered. out_valid is 1 for exactly one cycle: the fifth cycle after the accepting edge. In the following cycle in_ready is 1 again.
- R3: Each lane's shifted score is its signed score minus the signed maximum over all K lanes, saturated to the range [-128,127]. Lane i occupies bits [8i+7:8i] of in_score and of out_weight.
- R4: The shifted score's raw unsigned byte indexes the exponential table, and the entry read is treated as a signed byte. An entry of 255 therefore counts as -1.
- R5: The signed exponential bytes of all lanes are sign-extended and summed. The sum is clamped to [1,127] and then used as the index into the reciprocal table.
- R6: Each lane forms the exact signed product of its exponential byte and the signed reciprocal byte. It then shifts the product right arithmetically by 7, which rounds toward minus infinity (for example, -300 becomes -3).
- R7: The shifted value is saturated to signed 8 bits: values above 127 become 127 and values below -128 become -128.
- R8: With the standard tables loaded (an exponential table whose index 0 holds 255, and a reciprocal table whose index 1 holds 127), a vector with all lanes equal produces -1 in every output lane.
- R9: When tbl_we is 1 at a rising edge, tbl_data is written at tbl_addr. The target is the exponential table when tbl_sel is 0 and the reciprocal table when tbl_sel is 1. Vectors accepted after the write use the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector is valid |
| in_ready | output | 1 | Block can accept a vector |
| in_score | input | K*8 | Packed signed score lanes, six fractional bits |
| out_valid | output | 1 | One-cycle result strobe |
| out_weight | output | K*8 | Packed signed softmax weight lanes |
| tbl_we | input | 1 | Table write enable |
| tbl_sel | input | 1 | 0 selects the exponential table, 1 selects the reciprocal table |
| tbl_addr | input | 8 | Table entry index |
| tbl_data | input | 8 | Table entry value |

## Verification
The hardest condition to reach from the ports is saturation of the final byte. With sensible tables the largest product shifts down to at most 126, so output saturation never happens. To reach it, the stimulus reloads the exponential table so that every entry holds -128 and writes -128 into reciprocal entry 1. The exponential sum is then negative, clamps to index 1, and gives a product of 16384, which shifts to 128 and must saturate to 127. The same table rewrites are used to force a sum above 127 and a negative product that is not a multiple of 128. The latter separates a floor shift from truncation.

// File: rtl/sq8_softmax_pkg.sv
package sq8_softmax_pkg;
   localparam int BYTE_W = 8;

   typedef logic signed [BYTE_W-1:0] sbyte_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_MAX,
      ST_EXP,
      ST_SUM,
      ST_RCP,
      ST_OUT
   } sm_state_t;
endpackage

// File: rtl/sq8_lut_bank.sv
module sq8_lut_bank #(
   parameter int AW  = 8,
   parameter int DW  = 8,
   parameter int NRD = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DW-1:0]     wdata,
   input  logic [NRD*AW-1:0] raddr,
   output logic [NRD*DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 10) begin : g_bad_aw
      $error("sq8_lut_bank: AW out of range");
   end
   if (NRD < 1) begin : g_bad_nrd
      $error("sq8_lut_bank: NRD must be positive");
   end

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   for (genvar g = 0; g < NRD; g++) begin : g_rd
      assign rdata[g*DW +: DW] = mem[raddr[g*AW +: AW]];
   end

   // R9: a write is visible at its address on the following cycle
   a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/sq8_lane_max.sv
module sq8_lane_max #(
   parameter int K = 8,
   parameter int W = 8
) (
   input  logic [K*W-1:0]      vec,
   output logic signed [W-1:0] max_o
);
   if (K < 1) begin : g_bad_k
      $error("sq8_lane_max: K must be positive");
   end

   always_comb begin
      max_o = $signed(vec[W-1:0]);
      for (int i = 1; i < K; i++) begin
         if ($signed(vec[i*W +: W]) > max_o) max_o = $signed(vec[i*W +: W]);
      end
   end
endmodule

// File: rtl/sq8_softmax.sv
module sq8_softmax
   import sq8_softmax_pkg::*;
#(
   parameter int K = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [K*BYTE_W-1:0] in_score,
   output logic              out_valid,
   output logic [K*BYTE_W-1:0] out_weight,
   input  logic              tbl_we,
   input  logic              tbl_sel,
   input  logic [7:0]        tbl_addr,
   input  logic [7:0]        tbl_data
);
   localparam int SUM_W  = BYTE_W + $clog2(K) + 1;
   localparam int PROD_W = 2 * BYTE_W;
   localparam int SHIFT  = 7;

   if (K < 2 || K > 64) begin : g_bad_k
      $error("sq8_softmax: K must lie in [2,64]");
   end

   sm_state_t state;
   logic [K-1:0][BYTE_W-1:0] score_q, shift_q, exp_q, out_q, shift_d, out_d;
   logic [K*BYTE_W-1:0]      exp_rd;
   logic [BYTE_W-1:0]        sum_q, sum_d, rcp_rd;
   logic signed [BYTE_W-1:0] lane_max;
   logic signed [SUM_W-1:0]  sum_acc;

   assign in_ready   = (state == ST_IDLE);
   assign out_valid  = (state == ST_OUT);
   assign out_weight = out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
      end else begin
         case (state)
            ST_IDLE: if (in_valid) state <= ST_MAX;
            ST_MAX:  state <= ST_EXP;
            ST_EXP:  state <= ST_SUM;
            ST_SUM:  state <= ST_RCP;
            ST_RCP:  state <= ST_OUT;
            default: state <= ST_IDLE;
         endcase
      end
   end

   sq8_lane_max #(.K(K), .W(BYTE_W)) i_max (
      .vec   (score_q),
      .max_o (lane_max)
   );

   sq8_lut_bank #(.AW(8), .DW(BYTE_W), .NRD(K)) i_exp_tbl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (tbl_we && !tbl_sel),
      .waddr (tbl_addr),
      .wdata (tbl_data),
      .raddr (shift_q),
      .rdata (exp_rd)
   );

   sq8_lut_bank #(.AW(8), .DW(BYTE_W), .NRD(1)) i_rcp_tbl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (tbl_we && tbl_sel),
      .waddr (tbl_addr),
      .wdata (tbl_data),
      .raddr (sum_q),
      .rdata (rcp_rd)
   );

   for (genvar g = 0; g < K; g++) begin : g_lane
      logic signed [BYTE_W:0]   diff;
      logic signed [PROD_W-1:0] prod, scaled;

      assign diff = {score_q[g][BYTE_W-1], score_q[g]} - {lane_max[BYTE_W-1], lane_max};
      assign shift_d[g] = (diff < -128) ? 8'h80 : diff[BYTE_W-1:0];

      assign prod   = $signed(exp_q[g]) * $signed(rcp_rd);
      assign scaled = prod >>> SHIFT;
      assign out_d[g] = (scaled > 127)  ? 8'h7f :
                        (scaled < -128) ? 8'h80 : scaled[BYTE_W-1:0];

      // R3: after the subtraction no lane lies above the maximum
      a_r3_shift_nonpos: assert property (@(posedge clk) disable iff (!rst_n)
         (state == ST_EXP) |-> ($signed(shift_q[g]) <= 0));
      // R3: the reduction result bounds every lane
      a_r3_max_bound: assert property (@(posedge clk) disable iff (!rst_n)
         (state == ST_MAX) |-> (lane_max >= $signed(score_q[g])));
   end

   always_comb begin
      sum_acc = '0;
      for (int i = 0; i < K; i++) begin
         sum_acc = sum_acc + {{(SUM_W-BYTE_W){exp_q[i][BYTE_W-1]}}, exp_q[i]};
      end
      if (sum_acc < 1)        sum_d = 8'd1;
      else if (sum_acc > 127) sum_d = 8'd127;
      else                    sum_d = sum_acc[BYTE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         score_q <= '0;
         shift_q <= '0;
         exp_q   <= '0;
         sum_q   <= 8'd1;
         out_q   <= '0;
      end else begin
         if (state == ST_IDLE && in_valid) score_q <= in_score;
         if (state == ST_MAX) shift_q <= shift_d;
         if (state == ST_EXP) exp_q   <= exp_rd;
         if (state == ST_SUM) sum_q   <= sum_d;
         if (state == ST_RCP) out_q   <= out_d;
      end
   end

   // R2: the result strobe lasts one cycle and the input reopens after it
   a_r2_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> (!out_valid && in_ready));
   // R2: the result arrives a fixed five cycles after acceptance
   a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready, 5));
   // R2: no second vector is taken while one is in flight
   a_r2_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);
endmodule

// File: tb/test_sq8_softmax.sv
module test_sq8_softmax;
   localparam int K = 8;
   localparam int VW = K * 8;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          in_valid = 0;
   logic          in_ready;
   logic [VW-1:0] in_score = '0;
   logic          out_valid;
   logic [VW-1:0] out_weight;
   logic          tbl_we = 0;
   logic          tbl_sel = 0;
   logic [7:0]    tbl_addr = '0;
   logic [7:0]    tbl_data = '0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   byte exp_t [256];
   byte rcp_t [256];

   logic [VW-1:0] exp_queue [$];
   string         tag_queue [$];
   int            acc_queue [$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sq8_softmax #(.K(K)) i_sq8_softmax (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_score(in_score), .out_valid(out_valid), .out_weight(out_weight),
      .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_data(tbl_data)
   );

   task automatic chk(input string tag, input int act, input int exp_v);
      checks++;
      if (act != exp_v) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
      end
   endtask

   function automatic logic [VW-1:0] model(input logic [VW-1:0] v);
      int s [K];
      int e [K];
      int mx, sum, r, p, q, d;
      logic [VW-1:0] res;
      mx = -1000;
      for (int i = 0; i < K; i++) begin
         s[i] = int'($signed(v[i*8 +: 8]));
         if (s[i] > mx) mx = s[i];
      end
      sum = 0;
      for (int i = 0; i < K; i++) begin
         d = s[i] - mx;
         if (d < -128) d = -128;
         e[i] = int'(exp_t[d & 255]);
         sum += e[i];
      end
      if (sum < 1) sum = 1;
      if (sum > 127) sum = 127;
      r = int'(rcp_t[sum]);
      for (int i = 0; i < K; i++) begin
         p = e[i] * r;
         q = p >>> 7;
         if (q > 127) q = 127;
         if (q < -128) q = -128;
         res[i*8 +: 8] = q[7:0];
      end
      return res;
   endfunction

   task automatic tbl_write(input bit sel, input int addr, input byte val);
      @(negedge clk);
      tbl_we = 1; tbl_sel = sel; tbl_addr = addr[7:0]; tbl_data = val;
      if (sel) rcp_t[addr] = val; else exp_t[addr] = val;
      @(negedge clk);
      tbl_we = 0;
   endtask

   task automatic load_std;
      for (int b = 0; b < 256; b++) begin
         int s, v;
         s = (b < 128) ? b : b - 256;
         v = int'($exp(real'(s) / 64.0) * 256.0);
         if (v > 255) v = 255;
         tbl_write(0, b, byte'(v));
         if (s == 0) v = 127;
         else begin
            v = int'(4096.0 / real'(s));
            if (v > 127) v = 127;
            if (v < -128) v = -128;
         end
         tbl_write(1, b, byte'(v));
      end
   endtask

   task automatic send(input logic [VW-1:0] v, input string tag,
                       input bit use_x, input logic [VW-1:0] xv);
      exp_queue.push_back(use_x ? xv : model(v));
      tag_queue.push_back(tag);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1; in_score = v;
      acc_queue.push_back(cyc + 1);
      @(negedge clk);
      in_valid = 0;
   endtask

   task automatic drain;
      while (exp_queue.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   function automatic logic [VW-1:0] fill(input byte b);
      logic [VW-1:0] r;
      for (int i = 0; i < K; i++) r[i*8 +: 8] = b;
      return r;
   endfunction

   // monitor: pops expected results and compares each lane
   initial begin
      forever begin
         @(negedge clk);
         if (out_valid) begin
            logic [VW-1:0] ev;
            string t;
            int a;
            if (exp_queue.size() == 0) begin
               chk("R2 unexpected output", 1, 0);
            end else begin
               ev = exp_queue.pop_front();
               t  = tag_queue.pop_front();
               a  = acc_queue.pop_front();
               chk("R2 latency", cyc - a, 4);
               for (int i = 0; i < K; i++)
                  chk(t, int'($signed(out_weight[i*8 +: 8])), int'($signed(ev[i*8 +: 8])));
               @(negedge clk);
               chk("R2 single pulse", int'(out_valid), 0);
               chk("R2 ready returns", int'(in_ready), 1);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 in_ready after reset", int'(in_ready), 1);
      chk("R1 out_valid after reset", int'(out_valid), 0);
      rst_n = 1;
      load_std();

      // R8: uniform vectors give -1 everywhere
      send(fill(8'sd10), "R8 uniform 10", 1, fill(-8'sd1));
      send(fill(-8'sd20), "R8 uniform -20", 1, fill(-8'sd1));
      send(fill(8'sd127), "R8 uniform 127", 1, fill(-8'sd1));
      // R3: saturating subtraction on a wide spread
      send({8'sd127, 8'h80, 8'sd0, 8'h80, 8'sd1, 8'h80, 8'sd64, 8'hC0}, "R3 spread", 0, '0);
      // R4 R5 R6: mixed patterns through the standard tables
      send({8'sd0, 8'hF0, 8'hE0, 8'hD0, 8'hC0, 8'hB0, 8'hA0, 8'h90}, "R4 ramp", 0, '0);
      send({8'sd5, 8'sd5, 8'sd4, 8'sd3, 8'sd0, 8'hFC, 8'hF8, 8'hF0}, "R5 close", 0, '0);
      for (int n = 0; n < 6; n++) begin
         logic [VW-1:0] rv;
         for (int i = 0; i < K; i++) rv[i*8 +: 8] = 8'($urandom);
         send(rv, "R6 random", 0, '0);
      end
      drain();

      // R9 R7: rewrite tables to force output saturation
      for (int b = 0; b < 256; b++) tbl_write(0, b, 8'sh80);
      tbl_write(1, 1, 8'sh80);
      send(fill(8'sd3), "R7 saturate high", 1, fill(8'sd127));
      drain();
      // R6: floor shift of a negative product (-3*100 = -300 -> -3)
      for (int b = 0; b < 256; b++) tbl_write(0, b, -8'sd3);
      tbl_write(1, 1, 8'sd100);
      send(fill(-8'sd7), "R6 floor shift", 1, fill(-8'sd3));
      drain();
      // R5: sum above 127 clamps to index 127 (100*50 >>> 7 = 39)
      for (int b = 0; b < 256; b++) tbl_write(0, b, 8'sd100);
      tbl_write(1, 127, 8'sd50);
      send({8'sd1, 8'sd2, 8'sd3, 8'sd4, 8'sd5, 8'sd6, 8'sd7, 8'sd8}, "R5 clamp high", 1, fill(8'sd39));
      drain();
      // R9: exp table select leaves the reciprocal table intact
      tbl_write(0, 0, 8'sd64);
      send(fill(8'sd0), "R9 table select", 0, '0);
      drain();

      chk("R2 queue empty", exp_queue.size(), 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule